// File: doc/BRIEF.md
# Daisy-Chain Serial Frame Port with CRC-8

This block is the serial slave port of one device in a chain of stacked monitoring devices. A host, or the device below, exchanges fixed 32-bit frames with it over a four-wire serial link in clock mode 1. The clock idles low, each side changes its data on the rising clock edge, and the receiver captures on the falling edge. Every frame is bracketed by an active-low select. All serial inputs are brought into the system clock domain through a synchronizer, and the edges are detected there.

An incoming frame carries these fields:
- a 5-bit device number;
- a 6-bit register number;
- an 8-bit data byte;
- a broadcast bit and a write bit;
- an 8-bit CRC over the upper 22 bits.

A frame whose CRC checks and which is addressed to this device, or broadcast, moves the read pointer. If its write bit is set, it also writes the register file. A frame whose CRC does not check raises an error flag.

During each frame the port shifts out a 32-bit response that describes its state at the start of that frame. The response holds the register selected by the read pointer and carries its own CRC. Clocks beyond the 32nd relay the upstream device's serial data with a delay of exactly 32 clocks. A chain of N devices can therefore be read with one frame of 32·N clocks.

Top module: `chain_frame_port`

## Requirements
- R1: After reset, `sdo`, `wr_en`, `crc_err` and `rd_addr` are all 0.
- R2: An incoming frame is decoded with this bit layout:
  - bits 31..27: device number;
  - bits 26..21: register number;
  - bits 20..13: data byte;
  - bit 12: broadcast;
  - bit 11: write;
  - bit 10: reserved;
  - bits 9..2: CRC.

  A 32-clock frame with a good CRC, the write bit set and a device number equal to `dev_id` gives exactly one single-cycle `wr_en` pulse. During that pulse, `wr_addr` is the register number and `wr_data` is the data byte.
- R3: With the broadcast bit (bit 12) set, a good-CRC frame is accepted whatever its device number.
- R4: A good-CRC frame with broadcast clear and a device number other than `dev_id` writes nothing and leaves `rd_addr` unchanged.
- R5: A 32-clock frame whose CRC field differs from the computed CRC writes nothing and leaves `rd_addr` unchanged, and it sets `crc_err` to 1. The next 32-clock frame with a good CRC, addressed or not, returns `crc_err` to 0.
- R6: A frame that ends with the select rising after any clock count other than 32 is ignored: no write, and no change of `crc_err` or `rd_addr`.
- R7: An accepted frame, write or read (bit 11 clear), sets `rd_addr` to its register number. A read frame gives no `wr_en`.
- R8: During a frame, the first 32 bits on `sdo` are sent MSB first, each bit presented after a rising clock edge. They have this layout, taken at the start of the frame:
  - bits 31..27: `dev_id`;
  - bits 26..21: `rd_addr`;
  - bits 20..13: `rd_data`;
  - bit 12: `crc_err`;
  - bits 11..10: 0;
  - bits 9..2: CRC;
  - bits 1..0: 0.
- R9: The CRC is the remainder of bits 31..10, followed by eight zero bits, divided by the polynomial x^8+x^5+x^3+x^2+x+1 (0x12F). It is computed with a zero start value and no final inversion, and is the same for incoming and outgoing frames.
- R10: In a frame longer than 32 clocks, the bit sent after rising edge k (k ≥ 32) is the `sdi_up` value captured at falling edge k−32. The clock counter saturates instead of wrapping.
- R11: `sdo` is 0 while the select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_id | input | 5 | This device's position in the chain |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Command data from the host or the device below |
| sdi_up | input | 1 | Serial data from the device above |
| sdo | output | 1 | Serial response and relay output |
| wr_en | output | 1 | Single-cycle register-file write strobe |
| wr_addr | output | 6 | Register-file write address |
| wr_data | output | 8 | Register-file write data |
| rd_addr | output | 6 | Read pointer into the register file |
| rd_data | input | 8 | Register-file data at `rd_addr` |
| crc_err | output | 1 | CRC of the last 32-clock frame was wrong |

## Verification
The port is driven with the following frame patterns:
- read frames and write frames at register 0, register 63 and a middle register;
- frames addressed to another device, with and without broadcast;
- a frame with one flipped CRC bit;
- 31-, 33- and 64-clock frames.

Addressing is separated from broadcast by the other-device frames. The flipped CRC bit shows whether the check really compares the computed CRC. The frames of wrong length show whether acceptance is gated on the clock count and not on the select alone. The 64-clock frame, carrying a known upstream word, shows whether the relay delay is exactly 32 clocks. Each response is also compared bit by bit with a value built from an independent long-division CRC, so a wrong field position or a wrong bit order in the outgoing frame shows up.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int FRAME_BITS = 32;
  localparam int DEV_W      = 5;
  localparam int REG_W      = 6;
  localparam int DATA_W     = 8;
  localparam int CRC_W      = 8;
  // bit positions the decoder and the far end both depend on
  localparam int DEV_LSB    = 27;
  localparam int REG_LSB    = 21;
  localparam int DATA_LSB   = 13;
  localparam int BCAST_BIT  = 12;
  localparam int WRITE_BIT  = 11;
  localparam int COVER_LSB  = 10;
  localparam int CRC_LSB    = 2;
  localparam int COVER_W    = FRAME_BITS - COVER_LSB;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h2F;

  typedef struct packed {
    logic [DEV_W-1:0]  dev;
    logic [REG_W-1:0]  ptr;
    logic [DATA_W-1:0] data;
    logic              err;
    logic [1:0]        pad;
    logic [CRC_W-1:0]  crc;
    logic [1:0]        tail;
  } resp_frame_t;

  // MSB-first serial division, zero start, no final inversion
  function automatic logic [CRC_W-1:0] crc8_calc(input logic [COVER_W-1:0] msg);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = COVER_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ msg[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/cfp_sync.sv
module cfp_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 4,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/cfp_shifter.sv
module cfp_shifter
  import cfp_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_s,
  input  logic                       sclk_s,
  input  logic                       sdi_s,
  input  logic                       up_s,
  input  logic [FRAME_BITS-1:0]      load_word,
  output logic [FRAME_BITS-1:CRC_LSB] rx_word,
  output logic                       frame_end,
  output logic                       sdo
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_BITS);

  logic                  cs_prev, sclk_prev;
  logic                  cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [FRAME_BITS-1:0] tx_sr, rx_sr;
  logic [CNT_W-1:0]      bit_cnt;

  assign cs_fall   = !cs_s &&  cs_prev;
  assign cs_rise   =  cs_s && !cs_prev;
  assign sclk_rise =  sclk_s && !sclk_prev;
  assign sclk_fall = !sclk_s &&  sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
      tx_sr     <= '0;
      rx_sr     <= '0;
      bit_cnt   <= '0;
      sdo       <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      cs_prev   <= cs_s;
      sclk_prev <= sclk_s;
      frame_end <= 1'b0;
      if (cs_fall) begin
        tx_sr   <= load_word;
        bit_cnt <= '0;
        sdo     <= 1'b0;
      end else if (cs_rise) begin
        sdo       <= 1'b0;
        frame_end <= (bit_cnt == CNT_GOOD);
      end else if (!cs_s) begin
        if (sclk_rise) sdo <= tx_sr[FRAME_BITS-1];
        if (sclk_fall) begin
          tx_sr <= {tx_sr[FRAME_BITS-2:0], up_s};
          rx_sr <= {rx_sr[FRAME_BITS-2:0], sdi_s};
          if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign rx_word = rx_sr[FRAME_BITS-1:CRC_LSB];

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (!cs_s && !cs_fall && sclk_fall && bit_cnt == CNT_MAX) |=> (bit_cnt == CNT_MAX)); // R10
  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_s) |=> !sdo); // R11
  AST_END_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> $rose(cs_prev)); // R6
endmodule

// File: rtl/cfp_cmd.sv
module cfp_cmd
  import cfp_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DEV_W-1:0]            dev_id,
  input  logic                        frame_end,
  input  logic [FRAME_BITS-1:CRC_LSB] rx_word,
  input  logic [DATA_W-1:0]           rd_data,
  output logic                        wr_en,
  output logic [REG_W-1:0]            wr_addr,
  output logic [DATA_W-1:0]           wr_data,
  output logic [REG_W-1:0]            rd_addr,
  output logic                        crc_err,
  output logic [FRAME_BITS-1:0]       resp_word
);
  logic [DEV_W-1:0]  f_dev;
  logic [REG_W-1:0]  f_reg;
  logic [DATA_W-1:0] f_data;
  logic [CRC_W-1:0]  f_crc;
  logic              f_bcast, f_write, crc_ok, hit;
  resp_frame_t       resp;

  assign f_dev   = rx_word[DEV_LSB +: DEV_W];
  assign f_reg   = rx_word[REG_LSB +: REG_W];
  assign f_data  = rx_word[DATA_LSB +: DATA_W];
  assign f_bcast = rx_word[BCAST_BIT];
  assign f_write = rx_word[WRITE_BIT];
  assign f_crc   = rx_word[CRC_LSB +: CRC_W];
  assign crc_ok  = (crc8_calc(rx_word[FRAME_BITS-1:COVER_LSB]) == f_crc);
  assign hit     = f_bcast || (f_dev == dev_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_addr <= '0;
      crc_err <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (frame_end) begin
        crc_err <= !crc_ok;
        if (crc_ok && hit) begin
          rd_addr <= f_reg;
          if (f_write) begin
            wr_en   <= 1'b1;
            wr_addr <= f_reg;
            wr_data <= f_data;
          end
        end
      end
    end
  end

  always_comb begin
    resp      = '0;
    resp.dev  = dev_id;
    resp.ptr  = rd_addr;
    resp.data = rd_data;
    resp.err  = crc_err;
    resp.crc  = crc8_calc(resp[FRAME_BITS-1:COVER_LSB]);
  end

  assign resp_word = resp;

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R2
  AST_WR_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(frame_end)); // R2
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_end) |-> $stable(crc_err)); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_end) |-> $stable(rd_addr)); // R7
endmodule

// File: rtl/chain_frame_port.sv
module chain_frame_port
  import cfp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEV_W-1:0]  dev_id,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              sdi_up,
  output logic              sdo,
  output logic              wr_en,
  output logic [REG_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [REG_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              crc_err
);
  localparam int IN_W = 4;

  logic [IN_W-1:0]               in_s;
  logic [FRAME_BITS-1:CRC_LSB]   rx_word;
  logic [FRAME_BITS-1:0]         resp_word;
  logic                          frame_end;

  cfp_sync #(
    .STAGES (SYNC_STAGES),
    .W      (IN_W),
    .RST_VAL(4'b0001)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({sdi_up, sdi, sclk, cs_n}),
    .dout(in_s)
  );

  cfp_shifter #(
    .CNT_W(CNT_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (in_s[0]),
    .sclk_s   (in_s[1]),
    .sdi_s    (in_s[2]),
    .up_s     (in_s[3]),
    .load_word(resp_word),
    .rx_word  (rx_word),
    .frame_end(frame_end),
    .sdo      (sdo)
  );

  cfp_cmd u_cmd (
    .clk      (clk),
    .rst      (rst),
    .dev_id   (dev_id),
    .frame_end(frame_end),
    .rx_word  (rx_word),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .crc_err  (crc_err),
    .resp_word(resp_word)
  );
endmodule

// File: tb/sim_chain_frame_port.sv
module sim_chain_frame_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 6;
  localparam int WD_LIMIT   = 150000;
  localparam logic [4:0] DEV = 5'd9;

  logic       clk = 1'b0, rst = 1'b1;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, sdi_up = 1'b0;
  logic [4:0] dev_id = DEV;
  logic       sdo, wr_en, crc_err;
  logic [5:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  logic [7:0]  env_mem [64];
  logic [7:0]  exp_mem [64];
  logic [13:0] got_q [$];
  int          exp_ptr = 0;
  bit          exp_err = 1'b0;
  int          checks = 0, fails = 0, cyc = 0, idle = 0;

  chain_frame_port u0 (
    .clk(clk), .rst(rst), .dev_id(dev_id), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdi_up(sdi_up), .sdo(sdo), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .crc_err(crc_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_data = env_mem[rd_addr];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) env_mem[i] <= 8'(i * 37 + 11);
    end else if (wr_en) begin
      env_mem[wr_addr] <= wr_data;
    end
  end

  function automatic logic [7:0] bcrc(input logic [21:0] m);
    logic [29:0] r;
    r = {m, 8'h00};
    for (int i = 29; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h12F;
    return r[7:0];
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] d, input logic [5:0] r,
                                     input logic [7:0] v, input bit all,
                                     input bit wr, input bit bad);
    logic [31:0] w;
    logic [7:0]  c;
    w = {d, r, v, all, wr, 1'b0, 8'h00, 2'b00};
    c = bcrc(w[31:10]);
    if (bad) c = c ^ 8'h01;
    w[9:2] = c;
    return w;
  endfunction

  function automatic logic [31:0] exp_resp();
    logic [31:0] w;
    w = {DEV, 6'(exp_ptr), exp_mem[exp_ptr], exp_err, 2'b00, 8'h00, 2'b00};
    w[9:2] = bcrc(w[31:10]);
    return w;
  endfunction

  task automatic check_eq(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // per-clock: write strobes collected, idle output compared (R11)
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) got_q.push_back({wr_addr, wr_data});
      if (cs_n) idle++; else idle = 0;
      if (idle > 5) check_eq("R11", "sdo while deselected", 32'(sdo), 32'd0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WD_LIMIT);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic frame(input logic [31:0] w, input int nbits,
                       input logic [31:0] up, input string tag);
    logic [31:0] er, own, rel;
    bit          ok, hit, expect_wr;
    er  = exp_resp();
    own = '0;
    rel = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      sclk   = 1'b1;
      sdi    = (k < 32) ? w[31-k] : 1'b0;
      sdi_up = (k < 32) ? up[31-k] : 1'b0;
      repeat (HALF_SCLK) @(negedge clk);
      if (k < 32) own[31-k] = sdo;
      else if (k < 64) rel[63-k] = sdo;
      sclk = 1'b0;
      repeat (HALF_SCLK) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1; sdi = 1'b0; sdi_up = 1'b0;
    repeat (10) @(negedge clk);
    // reference model from the requirements
    expect_wr = 1'b0;
    if (nbits == 32) begin
      ok  = (bcrc(w[31:10]) == w[9:2]);
      hit = w[12] || (w[31:27] == DEV);
      exp_err = !ok;
      if (ok && hit) begin
        exp_ptr = int'(w[26:21]);
        if (w[11]) begin
          expect_wr = 1'b1;
          exp_mem[w[26:21]] = w[20:13];
        end
      end
    end
    if (nbits >= 32) begin
      check_eq("R8", "response word", own, er);
      check_eq("R9", "response CRC field", 32'(own[9:2]), 32'(er[9:2]));
    end
    if (nbits >= 64) check_eq("R10", "relayed upstream word", rel, up);
    if (expect_wr) begin
      check_eq(tag, "write count", 32'(got_q.size()), 32'd1);
      if (got_q.size() == 1) check_eq(tag, "write addr/data", 32'(got_q[0]), 32'(w[26:13]));
    end else begin
      check_eq(tag, "write count", 32'(got_q.size()), 32'd0);
    end
    got_q.delete();
    check_eq(tag, "rd_addr (R7)", 32'(rd_addr), 32'(exp_ptr));
    check_eq(tag, "crc_err (R5)", 32'(crc_err), 32'(exp_err));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) exp_mem[i] = 8'(i * 37 + 11);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1", "sdo after reset", 32'(sdo), 32'd0);
    check_eq("R1", "wr_en after reset", 32'(wr_en), 32'd0);
    check_eq("R1", "crc_err after reset", 32'(crc_err), 32'd0);
    check_eq("R1", "rd_addr after reset", 32'(rd_addr), 32'd0);

    frame(mk(DEV, 6'd5, 8'h00, 1'b0, 1'b0, 1'b0), 32, 32'h0, "R7");
    frame(mk(DEV, 6'd5, 8'hA5, 1'b0, 1'b1, 1'b0), 32, 32'h0, "R2");
    frame(mk(DEV, 6'd0, 8'h3C, 1'b0, 1'b1, 1'b0), 32, 32'h0, "R2");
    frame(mk(DEV, 6'd63, 8'hFF, 1'b0, 1'b1, 1'b0), 32, 32'h0, "R2");
    frame(mk(DEV, 6'd5, 8'h00, 1'b0, 1'b0, 1'b0), 32, 32'h0, "R7");
    frame(mk(5'd3, 6'd10, 8'h77, 1'b0, 1'b1, 1'b0), 32, 32'h0, "R4");
    frame(mk(5'd4, 6'd7, 8'h00, 1'b0, 1'b0, 1'b0), 32, 32'h0, "R4");
    frame(mk(5'd3, 6'd10, 8'h66, 1'b1, 1'b1, 1'b0), 32, 32'h0, "R3");
    frame(mk(DEV, 6'd12, 8'h11, 1'b0, 1'b1, 1'b1), 32, 32'h0, "R5");
    frame(mk(DEV, 6'd13, 8'h22, 1'b0, 1'b1, 1'b0), 31, 32'h0, "R6");
    frame(mk(DEV, 6'd13, 8'h22, 1'b0, 1'b1, 1'b0), 33, 32'h0, "R6");
    frame(mk(DEV, 6'd13, 8'h22, 1'b0, 1'b1, 1'b0), 64, 32'hC3A5_0F96, "R10");
    frame(mk(5'd2, 6'd20, 8'h00, 1'b0, 1'b0, 1'b0), 32, 32'h0, "R5");
    frame(mk(DEV, 6'd10, 8'h00, 1'b0, 1'b0, 1'b0), 32, 32'h0, "R7");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule